// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

The controller gathers a vector of level-sensitive interrupt requests (32 by default) and presents it to a processor as two independent request lines. One line is a normal interrupt and the other is a fast interrupt. Each line has its own enable mask. Software changes a mask only by setting bits through one word offset and clearing bits through another, so two agents never need a read-modify-write to share it.

Software can also raise a request on source 0 without any external device. This request is ORed with the external line 0. Software reads status as raw levels or as masked levels for either output, over a plain 32-bit register bus addressed by word offset. A write takes effect at the next clock edge. Read data is combinational from the offset. The input levels are sampled once per clock, and the outputs follow the registered state with no further delay.

There is no state machine. The register decode is a `unique case` over an enumerated set of word offsets. The named offsets are:

| Offset | Name | Access |
|---|---|---|
| 0 | OFS_IRQ_MSK | read |
| 1 | OFS_IRQ_RAW | read |
| 2 | OFS_IRQ_ENS | read/write |
| 3 | OFS_IRQ_ENC | write |
| 4 | OFS_SW_SET | read/write |
| 5 | OFS_SW_CLR | write |
| 8 | OFS_FIQ_MSK | read |
| 9 | OFS_FIQ_RAW | read |
| 10 | OFS_FIQ_ENS | read/write |
| 11 | OFS_FIQ_ENC | write |

Every other offset falls to the default arm.

Top module: `dual_vic`

## Requirements
- R1: The raw level vector equals `src_i` as sampled at the previous rising clock edge, with bit 0 also ORed with the software request. It reads back at both offset 1 and offset 9.
- R2: `irq_o` is high exactly when (raw AND IRQ enable mask) is nonzero. Offset 0 reads that masked vector.
- R3: `fiq_o` is high exactly when (raw AND FIQ enable mask) is nonzero. Offset 8 reads that masked vector.
- R4: A write to offset 2 ORs the write data into the IRQ enable mask. Offset 2 reads the mask back.
- R5: A write to offset 3 clears each IRQ enable bit whose write data bit is 1 and leaves the other bits unchanged.
- R6: A write to offset 10 ORs the write data into the FIQ enable mask. Offset 10 reads the mask back.
- R7: A write to offset 11 clears each FIQ enable bit whose write data bit is 1 and leaves the other bits unchanged.
- R8: A write to offset 4 with data bit 0 at 1 sets the software request, and a write to offset 5 with data bit 0 at 1 clears it. Writes to either offset with bit 0 at 0 have no effect. Offset 4 returns the request in read bit 0, with zeros above it.
- R9: Reads of offsets 3, 5 and 11, and of the unassigned offsets 6, 7 and 12 to 15, return zero. Writes to the read-only offsets 0, 1, 8 and 9 change no state.
- R10: Reset (active-low `rst_n`) clears both enable masks, the software request and the sampled levels, so both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_i | input | 32 | Level-sensitive interrupt requests |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two things can land on the same clock edge: a change on a request input and a write that changes an enable mask or the software request. When they do, both must appear in the next cycle's outputs. The bench provokes this by driving a new `src_i` pattern in the same half-cycle as a mask-clear or software-request write, aimed at the same bit or at a neighbouring bit. It then judges the register reads and both output lines one cycle later against a model that applies the input and the write together.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int DATA_W  = 32;
    localparam int NUM_OUT = 2;   // index 0: normal, index 1: fast

    typedef enum logic [3:0] {
        OFS_IRQ_MSK = 4'd0,
        OFS_IRQ_RAW = 4'd1,
        OFS_IRQ_ENS = 4'd2,
        OFS_IRQ_ENC = 4'd3,
        OFS_SW_SET  = 4'd4,
        OFS_SW_CLR  = 4'd5,
        OFS_FIQ_MSK = 4'd8,
        OFS_FIQ_RAW = 4'd9,
        OFS_FIQ_ENS = 4'd10,
        OFS_FIQ_ENC = 4'd11
    } vic_ofs_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [NUM_OUT-1:0][NUM_SRC-1:0]     en_o,
    output logic                                soft_o
);
    // One mask per output, each with its own set and clear offset.
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_mask
        localparam logic [ADDR_W-1:0] SET_A =
            (g == 0) ? ADDR_W'(OFS_IRQ_ENS) : ADDR_W'(OFS_FIQ_ENS);
        localparam logic [ADDR_W-1:0] CLR_A =
            (g == 0) ? ADDR_W'(OFS_IRQ_ENC) : ADDR_W'(OFS_FIQ_ENC);

        logic [NUM_SRC-1:0] mask_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else if (wr_en && addr == SET_A) begin
                mask_q <= mask_q | wdata[NUM_SRC-1:0];
            end else if (wr_en && addr == CLR_A) begin
                mask_q <= mask_q & ~wdata[NUM_SRC-1:0];
            end
        end

        assign en_o[g] = mask_q;
    end

    // Software request on source 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_o <= 1'b0;
        end else if (wr_en && wdata[0] && addr == ADDR_W'(OFS_SW_SET)) begin
            soft_o <= 1'b1;
        end else if (wr_en && wdata[0] && addr == ADDR_W'(OFS_SW_CLR)) begin
            soft_o <= 1'b0;
        end
    end
endmodule

// File: rtl/vic_level.sv
module vic_level #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               soft_i,
    output logic [NUM_SRC-1:0] raw_o
);
    logic [NUM_SRC-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= src_i;
        end
    end

    assign raw_o = level_q | NUM_SRC'(soft_i);
endmodule

// File: rtl/vic_outgen.sv
module vic_outgen
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]              raw_i,
    input  logic [NUM_OUT-1:0][NUM_SRC-1:0] en_i,
    output logic [NUM_OUT-1:0][NUM_SRC-1:0] masked_o,
    output logic [NUM_OUT-1:0]              req_o
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        assign masked_o[g] = raw_i & en_i[g];
        assign req_o[g]    = |masked_o[g];
    end
endmodule

// File: rtl/dual_vic.sv
module dual_vic
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       src_i,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [NUM_OUT-1:0][NUM_SRC-1:0] en_w;
    logic [NUM_OUT-1:0][NUM_SRC-1:0] masked_w;
    logic [NUM_OUT-1:0]              req_w;
    logic [NUM_SRC-1:0]              raw_w;
    logic [NUM_SRC-1:0]              irq_en_w;
    logic [NUM_SRC-1:0]              fiq_en_w;
    logic                            soft_w;
    vic_ofs_e                        ofs;

    vic_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .en_o   (en_w),
        .soft_o (soft_w)
    );

    vic_level #(.NUM_SRC(NUM_SRC)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i[NUM_SRC-1:0]),
        .soft_i (soft_w),
        .raw_o  (raw_w)
    );

    vic_outgen #(.NUM_SRC(NUM_SRC)) u_out (
        .raw_i    (raw_w),
        .en_i     (en_w),
        .masked_o (masked_w),
        .req_o    (req_w)
    );

    assign irq_en_w = en_w[0];
    assign fiq_en_w = en_w[1];
    assign irq_o    = req_w[0];
    assign fiq_o    = req_w[1];
    assign ofs      = vic_ofs_e'(bus_addr);

    always_comb begin
        unique case (ofs)
            OFS_IRQ_MSK: bus_rdata = DATA_W'(masked_w[0]);
            OFS_IRQ_RAW,
            OFS_FIQ_RAW: bus_rdata = DATA_W'(raw_w);
            OFS_IRQ_ENS: bus_rdata = DATA_W'(irq_en_w);
            OFS_SW_SET:  bus_rdata = DATA_W'(soft_w);
            OFS_FIQ_MSK: bus_rdata = DATA_W'(masked_w[1]);
            OFS_FIQ_ENS: bus_rdata = DATA_W'(fiq_en_w);
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vic_checker.sv
module vic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq_o,
    input logic        fiq_o,
    input logic [31:0] irq_en,
    input logic [31:0] fiq_en
);
    assert_irq_vs_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd0) |-> (irq_o == (bus_rdata != 32'd0)));

    assert_fiq_vs_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd8) |-> (fiq_o == (bus_rdata != 32'd0)));

    assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd2) |=> ((irq_en & $past(bus_wdata)) == $past(bus_wdata)));

    assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd3) |=> ((irq_en & $past(bus_wdata)) == 32'd0));

    assert_fiq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd10) |=> ((fiq_en & $past(bus_wdata)) == $past(bus_wdata)));

    assert_fiq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd11) |=> ((fiq_en & $past(bus_wdata)) == 32'd0));

    assert_wo_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd3 || bus_addr == 4'd5 || bus_addr == 4'd6 || bus_addr == 4'd7 ||
         bus_addr >= 4'd11) |-> (bus_rdata == 32'd0));

    assert_ro_write_keeps_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 4'd0 || bus_addr == 4'd1 || bus_addr == 4'd8 ||
                    bus_addr == 4'd9)) |=> ($stable(irq_en) && $stable(fiq_en)));
endmodule

bind dual_vic vic_checker u_vic_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .irq_en    (irq_en_w),
    .fiq_en    (fiq_en_w)
);

// File: tb/tb_dual_vic.sv
module tb_dual_vic;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [3:0]  addr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic        exp_fiq;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_i = '0;
    logic        irq_o, fiq_o;

    // reference model state
    logic [31:0] m_src = '0, m_ien = '0, m_fen = '0;
    logic        m_soft = 1'b0;

    item_t q[$];
    event  sample_ev;
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;

    dual_vic dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] m_raw();
        return m_src | {31'd0, m_soft};
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:       return m_raw() & m_ien;
            4'd1, 4'd9: return m_raw();
            4'd2:       return m_ien;
            4'd4:       return {31'd0, m_soft};
            4'd8:       return m_raw() & m_fen;
            4'd10:      return m_fen;
            default:    return 32'd0;
        endcase
    endfunction

    // Driver side: one expected item per sampled read
    task automatic expect_rd(input logic [3:0] a, input string tag);
        item_t it;
        bus_addr = a;
        #1;
        it.addr    = a;
        it.exp_rd  = m_read(a);
        it.exp_irq = |(m_raw() & m_ien);
        it.exp_fiq = |(m_raw() & m_fen);
        it.tag     = tag;
        q.push_back(it);
        -> sample_ev;
        #0;
    endtask

    task automatic expect_all(input string tag);
        for (int a = 0; a < 16; a++) expect_rd(4'(a), tag);
    endtask

    // One cycle: optional write and new source pattern on the same edge
    task automatic cycle(input logic wr, input logic [3:0] a,
                         input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; src_i = s;
        @(negedge clk);
        bus_wr = 1'b0;
        m_src = s;
        if (wr) begin
            case (a)
                4'd2:  m_ien = m_ien | d;
                4'd3:  m_ien = m_ien & ~d;
                4'd10: m_fen = m_fen | d;
                4'd11: m_fen = m_fen & ~d;
                4'd4:  if (d[0]) m_soft = 1'b1;
                4'd5:  if (d[0]) m_soft = 1'b0;
                default: ;
            endcase
        end
    endtask

    // Monitor: pops expected items and compares with the design
    initial begin
        item_t it;
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                it = q.pop_front();
                vectors++;
                if (bus_rdata !== it.exp_rd || irq_o !== it.exp_irq || fiq_o !== it.exp_fiq) begin
                    miscompares++;
                    $display("FAIL %s addr=%0d rdata=%h exp=%h irq=%b exp=%b fiq=%b exp=%b",
                             it.tag, it.addr, bus_rdata, it.exp_rd, irq_o, it.exp_irq,
                             fiq_o, it.exp_fiq);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_all("R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: raw levels follow inputs one edge later, masks still zero
        cycle(1'b0, 4'd0, 32'd0, 32'hA5A5_0F0E);
        expect_rd(4'd1, "R1 raw at 1");
        expect_rd(4'd9, "R1 raw at 9");
        expect_rd(4'd0, "R2 masked irq zero");

        // R4 / R2: set IRQ enables, accumulate
        cycle(1'b1, 4'd2, 32'h0000_00F0, 32'hA5A5_0F0E);
        expect_rd(4'd2, "R4 irq enable set");
        expect_rd(4'd0, "R2 masked irq");
        cycle(1'b1, 4'd2, 32'h0F00_0000, 32'hA5A5_0F0E);
        expect_rd(4'd2, "R4 irq enable OR");
        // R5: clear some bits
        cycle(1'b1, 4'd3, 32'h0000_0030, 32'hA5A5_0F0E);
        expect_rd(4'd2, "R5 irq enable clear");
        expect_rd(4'd0, "R2 masked after clear");
        cycle(1'b0, 4'd0, 32'd0, 32'h0000_0000);
        expect_rd(4'd0, "R2 irq low with no source");

        // R6 / R7 / R3
        cycle(1'b1, 4'd10, 32'h8000_0001, 32'h8000_0000);
        expect_rd(4'd10, "R6 fiq enable set");
        expect_rd(4'd8, "R3 masked fiq");
        cycle(1'b1, 4'd10, 32'h0001_0000, 32'h8000_0000);
        expect_rd(4'd10, "R6 fiq enable OR");
        cycle(1'b1, 4'd11, 32'h8000_0000, 32'h8000_0000);
        expect_rd(4'd10, "R7 fiq enable clear");
        expect_rd(4'd8, "R3 fiq low after clear");

        // R8: software request on line 0
        cycle(1'b1, 4'd4, 32'hFFFF_FFFE, 32'd0);
        expect_rd(4'd4, "R8 set ignored without bit0");
        cycle(1'b1, 4'd4, 32'h0000_0001, 32'd0);
        expect_rd(4'd4, "R8 soft set");
        expect_rd(4'd1, "R8 soft in raw");
        expect_rd(4'd8, "R8 soft drives fiq");
        cycle(1'b1, 4'd5, 32'hFFFF_FFFE, 32'd0);
        expect_rd(4'd4, "R8 clear ignored without bit0");
        cycle(1'b1, 4'd5, 32'h0000_0001, 32'h0000_0001);
        expect_rd(4'd1, "R8 external line0 with soft cleared");
        expect_rd(4'd4, "R8 soft cleared");

        // R9: writes to read-only offsets, and reads of write-only ones
        cycle(1'b1, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001);
        cycle(1'b1, 4'd1, 32'hFFFF_FFFF, 32'h0000_0001);
        cycle(1'b1, 4'd8, 32'hFFFF_FFFF, 32'h0000_0001);
        cycle(1'b1, 4'd9, 32'hFFFF_FFFF, 32'h0000_0001);
        expect_all("R9 read-only writes ignored");

        // Same-edge input change and mask write
        cycle(1'b1, 4'd3, 32'h0F00_0000, 32'h0F00_0000);
        expect_all("R5 clear with input rise same edge");
        cycle(1'b1, 4'd2, 32'h0000_0040, 32'h0000_0040);
        expect_all("R4 set with input rise same edge");
        cycle(1'b1, 4'd4, 32'h1, 32'h0);
        expect_all("R8 soft set with input fall same edge");
        cycle(1'b1, 4'd11, 32'h0000_0001, 32'h0000_0001);
        expect_all("R7 fiq clear on line0 with soft held");

        // R10: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        m_ien = '0; m_fen = '0; m_soft = 1'b0; m_src = '0;
        src_i = '0;
        #1;
        expect_all("R10 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        #1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule